// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory that two ports can access at once. On every clock it compares the two port addresses and looks at the two enables. When both ports are enabled at the same location, it picks one port to proceed. It flags the other port with an active-low busy and suppresses that port's write strobe. Busy and the write gates are combinational in the current inputs, so a collision is flagged in the same cycle that it appears.

A small history of last cycle's enables and addresses decides the winner. If one port was already enabled when the other port's enable arrived on a shared address, the port that was enabled earlier wins. If both ports were already enabled and one port moved its address onto the other's, the port that did not move wins. When neither rule separates the ports, the left port wins. Once chosen, the winner is held for as long as the collision lasts.

A mode input selects between two roles. In master mode the block drives busy itself. In slave mode its busy outputs stay inactive, and an incoming busy line per port gates that port's write instead. Several devices can then share one arbitration decision when memories are cascaded.

Top module: `dpca_top`

## Requirements
- R1: In master mode (ms_sel=1), while both enables are high and the addresses are equal, exactly one of l_busy_n/r_busy_n is low in that same cycle.
- R2: While the enables are not both high, or the addresses differ, both busy outputs are high. Release happens in the same cycle the condition ends.
- R3: If the addresses are equal and exactly one port was enabled in the previous cycle when the other port's enable rises, the previously enabled port wins and the other port sees busy low.
- R4: If both ports were enabled in the previous cycle and exactly one port changes its address so that the addresses now match, the port whose address stayed unchanged wins.
- R5: When neither R3 nor R4 separates the ports, the left port wins, for example when both enables rise together or both addresses change together. This includes the first collision after reset.
- R6: The winner chosen when a collision begins is kept for every following cycle in which the collision continues, even if R3 to R5 would now pick the other port.
- R7: In master mode, l_wr_ok = l_ce & l_we & l_busy_n, and likewise for the right port. The busy inputs are ignored.
- R8: In slave mode (ms_sel=0), both busy outputs are high, and l_wr_ok = l_ce & l_we & l_busy_in_n, likewise for the right port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ms_sel | input | 1 | 1 = master (drive busy), 0 = slave (take busy in) |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write request |
| l_addr | input | AW | Left port address |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write request |
| r_addr | input | AW | Right port address |
| l_busy_in_n | input | 1 | Incoming busy for left port (slave mode) |
| r_busy_in_n | input | 1 | Incoming busy for right port (slave mode) |
| l_busy_n | output | 1 | Busy to left port, active low |
| r_busy_n | output | 1 | Busy to right port, active low |
| l_wr_ok | output | 1 | Gated left write strobe |
| r_wr_ok | output | 1 | Gated right write strobe |

## Verification
Collisions are started in four ways, and each gives a different correct winner:
- Enable-first, with the left port enabled first and then with the right port enabled first. This separates the enable-history rule from the default.
- Address-first, in both directions. This shows that address stability, not port identity, decides the winner.
- Both enables rising together, and both addresses moving together. These expose the left-wins tie.

A collision that continues after the right port has won checks that the winner is held rather than recomputed. Releases by address change and by enable drop, plus the same collision in slave mode with busy driven in, separate the master gating from the slave gating.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
  localparam int NSIDE = 2;
endpackage

// File: rtl/dpca_detect.sv
// Match detection plus arrival-order preference from last cycle's history.
module dpca_detect #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic          r_ce,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  output logic          hit,
  output dpca_pkg::side_e pref
);
  import dpca_pkg::*;

  logic          pl_ce_q, pr_ce_q;
  logic [AW-1:0] pl_addr_q, pr_addr_q;
  logic          pl_ce_d, pr_ce_d;
  logic [AW-1:0] pl_addr_d, pr_addr_d;
  logic          hist_en;
  logic          l_still, r_still, both_prev, r_first;

  // history next state
  always_comb begin
    hist_en   = 1'b1;
    pl_ce_d   = l_ce;
    pr_ce_d   = r_ce;
    pl_addr_d = l_addr;
    pr_addr_d = r_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_ce_q   <= 1'b0;
      pr_ce_q   <= 1'b0;
      pl_addr_q <= '0;
      pr_addr_q <= '0;
    end else if (hist_en) begin
      pl_ce_q   <= pl_ce_d;
      pr_ce_q   <= pr_ce_d;
      pl_addr_q <= pl_addr_d;
      pr_addr_q <= pr_addr_d;
    end
  end

  always_comb begin
    hit       = l_ce & r_ce & (l_addr == r_addr);
    l_still   = (pl_addr_q == l_addr);
    r_still   = (pr_addr_q == r_addr);
    both_prev = pl_ce_q & pr_ce_q;
    // right earlier by enable, or right held its address while left moved
    r_first   = (pr_ce_q & ~pl_ce_q) | (both_prev & r_still & ~l_still);
    pref      = r_first ? SIDE_R : SIDE_L;
  end
endmodule

// File: rtl/dpca_winner.sv
// Holds the winner for the life of a collision.
module dpca_winner (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  dpca_pkg::side_e pref,
  output dpca_pkg::side_e win
);
  import dpca_pkg::*;

  logic  coll_q, coll_d;
  side_e win_q, win_d;

  always_comb begin
    win    = coll_q ? win_q : pref;
    coll_d = hit;
    win_d  = hit ? win : SIDE_L;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_q <= 1'b0;
      win_q  <= SIDE_L;
    end else begin
      coll_q <= coll_d;
      win_q  <= win_d;
    end
  end
endmodule

// File: rtl/dpca_gate.sv
// Per-port busy output and write gate, chosen by master/slave role.
module dpca_gate (
  input  logic ms_sel,
  input  logic lose,
  input  logic ce,
  input  logic we,
  input  logic busy_in_n,
  output logic busy_n,
  output logic wr_ok
);
  logic blocked;
  always_comb begin
    busy_n  = ~(ms_sel & lose);
    blocked = ms_sel ? lose : ~busy_in_n;
    wr_ok   = ce & we & ~blocked;
  end
endmodule

// File: rtl/dpca_top.sv
module dpca_top #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_sel,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_ok,
  output logic          r_wr_ok
);
  import dpca_pkg::*;

  logic  hit;
  side_e pref, win;
  logic [NSIDE-1:0] ce_v, we_v, bin_v, bout_v, wok_v, lose_v;

  dpca_detect #(.AW(AW)) u_detect (
    .clk(clk), .rst_n(rst_n), .l_ce(l_ce), .r_ce(r_ce),
    .l_addr(l_addr), .r_addr(r_addr), .hit(hit), .pref(pref)
  );

  dpca_winner u_winner (
    .clk(clk), .rst_n(rst_n), .hit(hit), .pref(pref), .win(win)
  );

  assign ce_v  = {r_ce, l_ce};
  assign we_v  = {r_we, l_we};
  assign bin_v = {r_busy_in_n, l_busy_in_n};

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    assign lose_v[i] = hit & (logic'(win) != 1'(i));
    dpca_gate u_gate (
      .ms_sel(ms_sel), .lose(lose_v[i]), .ce(ce_v[i]), .we(we_v[i]),
      .busy_in_n(bin_v[i]), .busy_n(bout_v[i]), .wr_ok(wok_v[i])
    );
  end

  assign l_busy_n = bout_v[0];
  assign r_busy_n = bout_v[1];
  assign l_wr_ok  = wok_v[0];
  assign r_wr_ok  = wok_v[1];
endmodule

// File: rtl/dpca_checker.sv
module dpca_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_sel,
  input logic          l_ce,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic          r_ce,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in_n,
  input logic          r_busy_in_n,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_wr_ok,
  input logic          r_wr_ok
);
  logic same;
  assign same = l_ce & r_ce & (l_addr == r_addr);

  assert_one_loser_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && same) |-> ($countones({~l_busy_n, ~r_busy_n}) == 1));

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !same |-> (l_busy_n && r_busy_n));

  assert_hold_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && same && !l_busy_n) |=> (!(ms_sel && same) || !l_busy_n));

  assert_hold_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && same && !r_busy_n) |=> (!(ms_sel && same) || !r_busy_n));

  assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ms_sel |-> (l_wr_ok == (l_ce && l_we && l_busy_n)) && (r_wr_ok == (r_ce && r_we && r_busy_n)));

  assert_slave_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_sel |-> (l_busy_n && r_busy_n && (l_wr_ok == (l_ce && l_we && l_busy_in_n))
                 && (r_wr_ok == (r_ce && r_we && r_busy_in_n))));
endmodule

bind dpca_top dpca_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel), .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
  .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .l_busy_in_n(l_busy_in_n),
  .r_busy_in_n(r_busy_in_n), .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
);

// File: tb/tb_dpca_top.sv
`timescale 1ns/1ps
module tb_dpca_top;
  localparam int AW = 16;
  logic clk, rst_n, ms_sel;
  logic l_ce, l_we, r_ce, r_we, l_busy_in_n, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dpca_top #(.AW(AW)) dut (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive at negedge, settle 1 ns for sampling
  task automatic drv(logic lc, logic lw, int la, logic rc, logic rw, int ra);
    @(negedge clk);
    l_ce = lc; l_we = lw; l_addr = AW'(la);
    r_ce = rc; r_we = rw; r_addr = AW'(ra);
    #1;
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R2", "reset l_busy_n", l_busy_n, 1'b1);
    chk("R2", "reset r_busy_n", r_busy_n, 1'b1);
    chk("R7", "reset l_wr_ok", l_wr_ok, 1'b0);
  endtask

  task automatic t_ce_first();
    idle();
    drv(1, 0, 5, 0, 0, 5);
    chk("R2", "single enable l_busy_n", l_busy_n, 1'b1);
    drv(1, 1, 5, 1, 1, 5);
    chk("R3", "left earlier: r_busy_n", r_busy_n, 1'b0);
    chk("R3", "left earlier: l_busy_n", l_busy_n, 1'b1);
    chk("R7", "winner write l_wr_ok", l_wr_ok, 1'b1);
    chk("R7", "loser write r_wr_ok", r_wr_ok, 1'b0);
    drv(0, 0, 5, 1, 1, 5);
    chk("R2", "enable drop r_busy_n", r_busy_n, 1'b1);
    chk("R7", "released r_wr_ok", r_wr_ok, 1'b1);
    idle();
    drv(0, 0, 9, 1, 0, 9);
    drv(1, 0, 9, 1, 0, 9);
    chk("R3", "right earlier: l_busy_n", l_busy_n, 1'b0);
    chk("R3", "right earlier: r_busy_n", r_busy_n, 1'b1);
  endtask

  task automatic t_addr_first();
    idle();
    drv(1, 1, 5, 1, 1, 7);
    chk("R2", "mismatch busy", l_busy_n & r_busy_n, 1'b1);
    drv(1, 1, 5, 1, 1, 5);
    chk("R4", "left held: r_busy_n", r_busy_n, 1'b0);
    chk("R4", "left held: l_busy_n", l_busy_n, 1'b1);
    drv(1, 1, 5, 1, 1, 6);
    chk("R2", "address move releases r_busy_n", r_busy_n, 1'b1);
    drv(1, 1, 9, 1, 1, 7);
    drv(1, 1, 7, 1, 1, 7);
    chk("R4", "right held: l_busy_n", l_busy_n, 1'b0);
    chk("R4", "right held: r_busy_n", r_busy_n, 1'b1);
    chk("R7", "loser l_wr_ok", l_wr_ok, 1'b0);
    drv(1, 1, 7, 1, 1, 7);
    chk("R6", "winner kept: l_busy_n", l_busy_n, 1'b0);
    chk("R6", "winner kept: r_busy_n", r_busy_n, 1'b1);
    drv(1, 1, 7, 1, 1, 7);
    chk("R6", "winner kept again: l_busy_n", l_busy_n, 1'b0);
  endtask

  task automatic t_tie();
    idle();
    drv(1, 0, 3, 1, 0, 3);
    chk("R5", "joint enable: r_busy_n", r_busy_n, 1'b0);
    chk("R5", "joint enable: l_busy_n", l_busy_n, 1'b1);
    drv(1, 0, 1, 1, 0, 2);
    drv(1, 0, 4, 1, 0, 4);
    chk("R5", "joint move: r_busy_n", r_busy_n, 1'b0);
    chk("R1", "one loser", l_busy_n ^ r_busy_n, 1'b1);
  endtask

  task automatic t_slave();
    idle();
    ms_sel = 0;
    l_busy_in_n = 0; r_busy_in_n = 1;
    drv(1, 1, 8, 1, 1, 8);
    chk("R8", "slave l_busy_n", l_busy_n, 1'b1);
    chk("R8", "slave r_busy_n", r_busy_n, 1'b1);
    chk("R8", "slave blocked l_wr_ok", l_wr_ok, 1'b0);
    chk("R8", "slave free r_wr_ok", r_wr_ok, 1'b1);
    ms_sel = 1;
    l_busy_in_n = 0; r_busy_in_n = 0;
    drv(1, 1, 8, 1, 1, 8);
    chk("R7", "master ignores busy in: one write", l_wr_ok ^ r_wr_ok, 1'b1);
    l_busy_in_n = 1; r_busy_in_n = 1;
  endtask

  initial begin
    rst_n = 0; ms_sel = 1; l_busy_in_n = 1; r_busy_in_n = 1;
    l_ce = 0; l_we = 0; l_addr = '0; r_ce = 0; r_we = 0; r_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_ce_first();
    t_addr_first();
    t_tie();
    t_slave();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule